// File: doc/BRIEF.md
# Root Port Error Status and Interrupt Logic

This block sits at the top of a PCI Express hierarchy, on the root-port side of error reporting. Error messages arrive from downstream. Each one carries a severity and a 16-bit requester ID. The block records every message in a root error status register and keeps two source-ID registers: one for the first correctable error and one for the first uncorrectable error. It marks the case where a second error of the same class arrives before software has cleared the first. It also notes whether the first uncorrectable error was fatal.

Each of the three severities has its own enable bit in a command register. When an enabled severity arrives, the block raises an interrupt. With MSI enabled, that interrupt is a one-cycle request that carries a message number. With MSI disabled, it is a level on one of several INTx lines. Software can also enable a severity after errors of that severity are already latched. The command write then reports them: with MSI, any enable bit that rises against a latched error sends a request. With INTx, the line is recomputed from the enabled, latched errors.

Top module: `root_err_irq`

## Requirements
- R1: Reset clears the command register, every status flag, both source-ID registers, the MSI request and all INTx lines.
- R2: A correctable message (severity code 0) sets status bit 0. If bit 0 was already set, it also sets bit 1 and leaves the correctable source ID unchanged. Otherwise the message's source ID is latched as the correctable source.
- R3: A nonfatal (code 1) or fatal (code 2) message sets status bit 2. If bit 2 was already set, it also sets bit 3 and leaves the uncorrectable source ID unchanged. Otherwise the message's source ID is latched as the uncorrectable source.
- R4: A fatal message always sets bit 6. It sets bit 4 (first uncorrectable was fatal) only when bit 2 was clear before the message.
- R5: A nonfatal message sets bit 5.
- R6: A message whose severity enable is set raises an interrupt. The enables are command bit 0 for correctable, bit 1 for nonfatal and bit 2 for fatal. With MSI enabled, the interrupt is a one-cycle MSI request whose number output is the message number. Otherwise the INTx line chosen by the select input goes high. With the enable clear, no interrupt is raised.
- R7: Writing ones to status bits 6..0 clears those bits. A message in the same cycle is applied after the clear. Bits 11..7 of the status output show the message number, which is taken from its input one cycle earlier.
- R8: With MSI enabled, a command write sends one MSI request only when some enable bit goes from 0 to 1 while its received flag is set. The received flags are bit 0 for correctable, bit 5 for nonfatal and bit 6 for fatal. A write that raises no such bit sends nothing.
- R9: With MSI disabled, a command write sets the INTx level to the OR of (enable AND received flag) over the three severities. Otherwise the level changes only when a message raises it, so clearing status alone does not lower it. At most one INTx line is high at a time.
- R10: A message with severity code 3 changes no status bit, no source ID and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | An error message is presented this cycle |
| msg_sev | input | 2 | Severity: 0 correctable, 1 nonfatal, 2 fatal, 3 invalid |
| msg_src | input | SRC_W | Requester ID of the message |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 3 | New enables: bit0 correctable, bit1 nonfatal, bit2 fatal |
| sts_w1c_we | input | 1 | Write strobe for the status register |
| sts_w1c_data | input | 7 | Ones clear the matching status bits |
| msi_en | input | 1 | MSI enabled; otherwise INTx is used |
| intx_sel | input | SEL_W | Which INTx line carries the interrupt |
| irq_num_in | input | NUM_W | Interrupt message number |
| root_cmd | output | 3 | Command register |
| root_sts | output | 7+NUM_W | Status flags in bits 6..0, message number above |
| cor_src | output | SRC_W | Source ID of the first correctable error |
| unc_src | output | SRC_W | Source ID of the first uncorrectable error |
| msi_req | output | 1 | One-cycle MSI request |
| msi_num | output | NUM_W | Message number carried with the request |
| intx | output | INTX_LINES | INTx levels, at most one high |

## Verification
The block is first driven with a run of correctable, nonfatal and fatal messages with all enables on and MSI selected. That run separates the first-arrival path from the repeated-arrival path in both classes: the source IDs must stay with the first message, and the multiple bits must appear only on the second. A fatal message sent after a clear, with its enable off, tells the first-fatal case apart from a fatal that follows a nonfatal, and shows that a disabled severity stays silent. Repeated and non-rising command writes against latched status separate edge-triggered MSI delivery from level-based INTx recomputation. A later INTx phase shows that a status clear leaves the line high until the next command write.

// File: rtl/root_err_irq.sv
module root_err_irq #(
  parameter int SRC_W      = 16,
  parameter int NUM_W      = 5,
  parameter int INTX_LINES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  msg_valid,
  input  logic [1:0]            msg_sev,
  input  logic [SRC_W-1:0]      msg_src,
  input  logic                  cmd_we,
  input  logic [2:0]            cmd_wdata,
  input  logic                  sts_w1c_we,
  input  logic [6:0]            sts_w1c_data,
  input  logic                  msi_en,
  input  logic [(INTX_LINES>1 ? $clog2(INTX_LINES) : 1)-1:0] intx_sel,
  input  logic [NUM_W-1:0]      irq_num_in,
  output logic [2:0]            root_cmd,
  output logic [7+NUM_W-1:0]    root_sts,
  output logic [SRC_W-1:0]      cor_src,
  output logic [SRC_W-1:0]      unc_src,
  output logic                  msi_req,
  output logic [NUM_W-1:0]      msi_num,
  output logic [INTX_LINES-1:0] intx
);
  localparam int SEL_W = (INTX_LINES > 1) ? $clog2(INTX_LINES) : 1;
  localparam int FL_W  = 7;

  localparam int B_COR   = 0;
  localparam int B_MCOR  = 1;
  localparam int B_UNC   = 2;
  localparam int B_MUNC  = 3;
  localparam int B_FIRST = 4;
  localparam int B_NF    = 5;
  localparam int B_FT    = 6;

  logic [FL_W-1:0]  flags_q, flags_base, flags_d;
  logic [2:0]       cmd_q;
  logic [NUM_W-1:0] num_q;
  logic             lvl_q, lvl_d;
  logic             msi_q;

  wire is_cor = msg_valid && (msg_sev == 2'd0);
  wire is_nf  = msg_valid && (msg_sev == 2'd1);
  wire is_ft  = msg_valid && (msg_sev == 2'd2);
  wire is_unc = is_nf || is_ft;

  assign flags_base = sts_w1c_we ? (flags_q & ~sts_w1c_data) : flags_q;

  always_comb begin
    flags_d = flags_base;
    if (is_cor) begin
      if (flags_base[B_COR]) flags_d[B_MCOR] = 1'b1;
      flags_d[B_COR] = 1'b1;
    end
    if (is_unc) begin
      if (flags_base[B_UNC]) flags_d[B_MUNC] = 1'b1;
      flags_d[B_UNC] = 1'b1;
    end
    if (is_ft) begin
      if (!flags_base[B_UNC]) flags_d[B_FIRST] = 1'b1;
      flags_d[B_FT] = 1'b1;
    end
    if (is_nf) flags_d[B_NF] = 1'b1;
  end

  wire [2:0] rcv_vec  = {flags_d[B_FT], flags_d[B_NF], flags_d[B_COR]};
  wire       sev_hit  = (is_cor && cmd_q[0]) || (is_nf && cmd_q[1]) || (is_ft && cmd_q[2]);
  wire [2:0] rising   = cmd_wdata & ~cmd_q;
  wire       cmd_fire = cmd_we && |(rising & rcv_vec);

  always_comb begin
    lvl_d = lvl_q;
    if (!msi_en) begin
      if (cmd_we)       lvl_d = |(cmd_wdata & rcv_vec);
      else if (sev_hit) lvl_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      cmd_q   <= '0;
      num_q   <= '0;
      lvl_q   <= 1'b0;
      msi_q   <= 1'b0;
      cor_src <= '0;
      unc_src <= '0;
    end else begin
      flags_q <= flags_d;
      num_q   <= irq_num_in;
      lvl_q   <= lvl_d;
      msi_q   <= msi_en && (sev_hit || cmd_fire);
      if (cmd_we) cmd_q <= cmd_wdata;
      if (is_cor && !flags_base[B_COR]) cor_src <= msg_src;
      if (is_unc && !flags_base[B_UNC]) unc_src <= msg_src;
    end
  end

  assign root_cmd = cmd_q;
  assign root_sts = {num_q, flags_q};
  assign msi_req  = msi_q;
  assign msi_num  = num_q;

  for (genvar g = 0; g < INTX_LINES; g++) begin : g_intx
    assign intx[g] = lvl_q && (intx_sel == SEL_W'(g));
  end

  AST_COR_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cor && flags_q[B_COR] && !(sts_w1c_we && sts_w1c_data[B_COR])) |=> root_sts[B_MCOR]); // R2
  AST_COR_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cor && flags_q[B_COR] && !(sts_w1c_we && sts_w1c_data[B_COR])) |=> $stable(cor_src)); // R2
  AST_UNC_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_unc && flags_q[B_UNC] && !(sts_w1c_we && sts_w1c_data[B_UNC])) |=> $stable(unc_src)); // R3
  AST_FATAL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    is_ft |=> root_sts[B_FT]); // R4
  AST_MSI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> $past(msi_en)); // R6
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(root_cmd)); // R8
  AST_INTX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(intx)); // R9
  AST_BAD_SEV: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd3 && !sts_w1c_we) |=> $stable(root_sts[6:0])); // R10
endmodule

// File: tb/root_err_irq_tb.sv
module root_err_irq_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        msg_valid = 0;
  logic [1:0]  msg_sev = 0;
  logic [15:0] msg_src = 0;
  logic        cmd_we = 0;
  logic [2:0]  cmd_wdata = 0;
  logic        sts_w1c_we = 0;
  logic [6:0]  sts_w1c_data = 0;
  logic        msi_en = 0;
  logic [1:0]  intx_sel = 0;
  logic [4:0]  irq_num_in = 5'd9;
  logic [2:0]  root_cmd;
  logic [11:0] root_sts;
  logic [15:0] cor_src, unc_src;
  logic        msi_req;
  logic [4:0]  msi_num;
  logic [3:0]  intx;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  root_err_irq u_dut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && msi_req) begin
      if (exp_q.size() == 0) chk("R8 unexpected MSI", 1, 0);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, msi_num, e);
      end
    end
  end

  task automatic send(logic [1:0] sev, logic [15:0] src, bit expect_msi, string t);
    @(negedge clk);
    msg_valid = 1; msg_sev = sev; msg_src = src;
    if (expect_msi) begin exp_q.push_back(9); tag_q.push_back(t); end
    @(negedge clk);
    msg_valid = 0;
    #1;
  endtask

  task automatic wr_cmd(logic [2:0] v, bit expect_msi, string t);
    @(negedge clk);
    cmd_we = 1; cmd_wdata = v;
    if (expect_msi) begin exp_q.push_back(9); tag_q.push_back(t); end
    @(negedge clk);
    cmd_we = 0;
    #1;
  endtask

  task automatic clr(logic [6:0] m);
    @(negedge clk);
    sts_w1c_we = 1; sts_w1c_data = m;
    @(negedge clk);
    sts_w1c_we = 0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 sts", root_sts[6:0], 0);
    chk("R1 cmd", root_cmd, 0);
    chk("R1 src", cor_src | unc_src, 0);
    chk("R1 irq", {msi_req, intx}, 0);
    rst_n = 1;
    msi_en = 1;
    wr_cmd(3'b111, 0, "R8");
    send(2'd0, 16'h0100, 1, "R6 msi cor");
    chk("R2 sts first", root_sts[6:0], 7'h01);
    chk("R2 src first", cor_src, 16'h0100);
    send(2'd0, 16'h0200, 1, "R6 msi cor2");
    chk("R2 sts multi", root_sts[6:0], 7'h03);
    chk("R2 src kept", cor_src, 16'h0100);
    send(2'd1, 16'h0300, 1, "R6 msi nf");
    chk("R5 sts", root_sts[6:0], 7'h27);
    chk("R3 src first", unc_src, 16'h0300);
    send(2'd2, 16'h0400, 1, "R6 msi ft");
    chk("R4 sts no first-fatal", root_sts[6:0], 7'h6F);
    chk("R3 src kept", unc_src, 16'h0300);
    chk("R6 queue drained", exp_q.size(), 0);
    clr(7'h7F);
    chk("R7 cleared", root_sts[6:0], 0);
    chk("R7 number field", root_sts[11:7], 9);
    wr_cmd(3'b000, 0, "R8");
    send(2'd2, 16'h0500, 0, "R6");
    chk("R4 first fatal", root_sts[6:0], 7'h54);
    chk("R3 src relatched", unc_src, 16'h0500);
    wr_cmd(3'b100, 1, "R8 rising fatal");
    chk("R8 msi delivered", exp_q.size(), 0);
    wr_cmd(3'b100, 0, "R8");
    chk("R8 cmd value", root_cmd, 3'b100);
    wr_cmd(3'b101, 0, "R8");
    send(2'd3, 16'h0600, 0, "R10");
    chk("R10 sts", root_sts[6:0], 7'h54);
    chk("R10 srcs", {cor_src, unc_src}, {16'h0100, 16'h0500});
    msi_en = 0; intx_sel = 2;
    clr(7'h7F);
    wr_cmd(3'b000, 0, "R9");
    chk("R9 idle", intx, 0);
    send(2'd1, 16'h0700, 0, "R6");
    chk("R6 disabled no intx", intx, 0);
    wr_cmd(3'b010, 0, "R9");
    chk("R9 level up", intx, 4'b0100);
    wr_cmd(3'b001, 0, "R9");
    chk("R9 level down", intx, 0);
    send(2'd0, 16'h0800, 0, "R6");
    chk("R6 intx raised", intx, 4'b0100);
    clr(7'h7F);
    chk("R9 clear keeps level", intx, 4'b0100);
    wr_cmd(3'b001, 0, "R9");
    chk("R9 recomputed", intx, 0);
    repeat (2) @(negedge clk);
    chk("R8 no missing MSI", exp_q.size(), 0);
    finish_run();
  end
endmodule